// File: doc/BRIEF.md
# Chunked Grid Gather-Lookup Engine

This block keeps a two-dimensional grid of small data words. The grid is cut into tiles of two rows by four columns. A square compute region of lanes sits over the grid, inset from every edge by a halo of words. Each lane can fetch any of the eight words in the tile that currently lies beneath it. It can fetch nothing else. To reach data held in other tiles, the whole grid is rotated one tile at a time, with wrap-around at the edges, until the wanted tile arrives under the lane.

Every tile position carries a tag that names the tile the data originally came from. The tag travels with the data. A lane asks for a word by giving an original tile id and a slot number. It answers as soon as that tile is resident under it, and keeps the request waiting until then. One tile position is chosen as the observer. A checklist records every tile id that has passed under the observer, so that a full table walk can be declared finished.

Tables are written one grid row per cycle. Rotation commands that arrive while a table is being written are dropped.

Top module: `gridlk_engine`

## Requirements
- R1: While reset is high and in the cycle after it, `res_valid` is all zero, `seen` is all zero and `lookup_done` is low. Reset also drops every waiting request.
- R2: Each cycle with `load_valid` high writes `load_row` into the next grid row. The first such cycle writes row 0, and after the last row the next write goes to row 0 again. Word c of the row is `load_row[c*W +: W]`. The cycle that writes row 0 sets every tag back to its own position and clears the checklist.
- R3: The slot number selects a word inside the lane's tile. Slot bit 2 picks the row within the tile, and slot bits 1:0 pick the column within the tile.
- R4: A lane's request is served at the first clock edge at which the tile under the lane has a tag equal to the requested id. `res_valid` and `res_data` for that lane change at that edge, and `res_valid` stays high for exactly one cycle. Until then the request waits. A new request on a lane replaces the one that is waiting.
- R5: `shift_dir` 0 moves the data two rows toward row 0. Code 1 moves it two rows away from row 0. Code 2 moves it four columns toward column 0. Code 3 moves it four columns away from column 0. All moves wrap around, and each tile's tag moves with its data.
- R6: A rotation command is dropped in any cycle where `load_valid` is high, and in any cycle where a table write has started but has not yet reached its last row.
- R7: At every clock edge, the checklist bit for the tag under the observer tile is set. `lookup_done` is high exactly when all bits are set. Between table writes, bits are never cleared.
- R8: The tile at tile row r and tile column c has id r*NCC + c, where NCC = COLS/4. That id is its tag after reset or after a table write.
- R9: Lane k sits at lane row k / LC and lane column k % LC, where LC = COLS - 2*HALO. It covers grid word (row + HALO, column + HALO), and it reads the tile that contains that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Write one grid row this cycle |
| load_row | input | COLS*W | Row data, word c at bits c*W |
| shift_valid | input | 1 | Rotate the grid by one tile |
| shift_dir | input | 2 | Rotation direction code |
| req_valid | input | LANES | Per-lane new request |
| req_chunk | input | LANES*IDW | Per-lane requested tile id |
| req_slot | input | LANES*3 | Per-lane slot inside the tile |
| res_valid | output | LANES | Per-lane result strobe |
| res_data | output | LANES*W | Per-lane result word |
| seen | output | NCH | Checklist of tile ids seen by the observer |
| lookup_done | output | 1 | Every tile has been observed |

## Verification
The bench builds an 8x8 grid with a halo of 2. That gives four tile rows by two tile columns, eight tiles and sixteen lanes, with the observer at tile (1,0). At this size, four row moves bring a tile all the way round, and a sweep of eight states completes the checklist. Wrap-around, tag travel and checklist completion therefore all fall within a few dozen cycles. The lane-to-tile geometry is unchanged from the default size.

// File: rtl/gridlk_pkg.sv
`timescale 1ns/1ps
package gridlk_pkg;
    localparam int CHUNK_H = 2;
    localparam int CHUNK_W = 4;
    localparam int SLOT_W  = 3;
    typedef enum logic [1:0] {
        MOVE_N = 2'd0,
        MOVE_S = 2'd1,
        MOVE_W = 2'd2,
        MOVE_E = 2'd3
    } move_e;
endpackage

// File: rtl/gridlk_store.sv
`timescale 1ns/1ps
module gridlk_store import gridlk_pkg::*; #(
    parameter int ROWS = 20,
    parameter int COLS = 20,
    parameter int W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load_valid,
    input  logic [COLS*W-1:0]                 load_row,
    input  logic                              shift_valid,
    input  logic [1:0]                        shift_dir,
    output logic [ROWS-1:0][COLS-1:0][W-1:0]  cells,
    output logic                              load_start,
    output logic                              shift_take,
    output logic                              loading
);
    localparam int RW = $clog2(ROWS);

    typedef struct packed {
        logic [ROWS-1:0][COLS-1:0][W-1:0] cells;
        logic [RW-1:0]                    row;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        load_start = load_valid && (st_q.row == '0);
        shift_take = shift_valid && !load_valid && (st_q.row == '0);
        if (load_valid) begin
            st_d.cells[st_q.row] = load_row;
            st_d.row = (st_q.row == RW'(ROWS-1)) ? '0 : st_q.row + 1'b1;
        end else if (shift_take) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    case (move_e'(shift_dir))
                        MOVE_N: st_d.cells[r][c] = st_q.cells[(r+CHUNK_H)%ROWS][c];
                        MOVE_S: st_d.cells[r][c] = st_q.cells[(r+ROWS-CHUNK_H)%ROWS][c];
                        MOVE_W: st_d.cells[r][c] = st_q.cells[r][(c+CHUNK_W)%COLS];
                        default: st_d.cells[r][c] = st_q.cells[r][(c+COLS-CHUNK_W)%COLS];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cells   = st_q.cells;
    assign loading = (st_q.row != '0);
endmodule

// File: rtl/gridlk_tags.sv
`timescale 1ns/1ps
module gridlk_tags import gridlk_pkg::*; #(
    parameter int NCR    = 10,
    parameter int NCC    = 5,
    parameter int OBS_CR = 4,
    parameter int OBS_CC = 2,
    parameter int NCH    = NCR*NCC,
    parameter int IDW    = $clog2(NCH)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               load_start,
    input  logic                               shift_take,
    input  logic [1:0]                         shift_dir,
    output logic [NCR-1:0][NCC-1:0][IDW-1:0]   tags,
    output logic [NCH-1:0]                     seen,
    output logic                               done
);
    typedef struct packed {
        logic [NCR-1:0][NCC-1:0][IDW-1:0] tags;
        logic [NCH-1:0]                   seen;
    } tag_t;

    tag_t st_d, st_q;
    logic [NCR-1:0][NCC-1:0][IDW-1:0] ident;

    always_comb begin
        for (int r = 0; r < NCR; r++)
            for (int c = 0; c < NCC; c++)
                ident[r][c] = IDW'(r*NCC + c);
    end

    always_comb begin
        st_d = st_q;
        if (load_start) begin
            st_d.tags = ident;
            st_d.seen = '0;
        end else begin
            st_d.seen = st_q.seen | (NCH'(1) << st_q.tags[OBS_CR][OBS_CC]);
            if (shift_take) begin
                for (int r = 0; r < NCR; r++) begin
                    for (int c = 0; c < NCC; c++) begin
                        case (move_e'(shift_dir))
                            MOVE_N: st_d.tags[r][c] = st_q.tags[(r+1)%NCR][c];
                            MOVE_S: st_d.tags[r][c] = st_q.tags[(r+NCR-1)%NCR][c];
                            MOVE_W: st_d.tags[r][c] = st_q.tags[r][(c+1)%NCC];
                            default: st_d.tags[r][c] = st_q.tags[r][(c+NCC-1)%NCC];
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.tags <= ident;
            st_q.seen <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tags = st_q.tags;
    assign seen = st_q.seen;
    assign done = &st_q.seen;
endmodule

// File: rtl/gridlk_lanes.sv
`timescale 1ns/1ps
module gridlk_lanes import gridlk_pkg::*; #(
    parameter int ROWS = 20,
    parameter int COLS = 20,
    parameter int W    = 8,
    parameter int HALO = 2,
    parameter int NCR  = ROWS/CHUNK_H,
    parameter int NCC  = COLS/CHUNK_W,
    parameter int IDW  = $clog2(NCR*NCC),
    parameter int LANES = (ROWS-2*HALO)*(COLS-2*HALO)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ROWS-1:0][COLS-1:0][W-1:0]  cells,
    input  logic [NCR-1:0][NCC-1:0][IDW-1:0]  tags,
    input  logic [LANES-1:0]                  req_valid,
    input  logic [LANES*IDW-1:0]              req_chunk,
    input  logic [LANES*SLOT_W-1:0]           req_slot,
    output logic [LANES-1:0]                  res_valid,
    output logic [LANES*W-1:0]                res_data,
    output logic [LANES-1:0]                  pend
);
    localparam int LR  = ROWS - 2*HALO;
    localparam int LC  = COLS - 2*HALO;
    localparam int RIW = $clog2(ROWS);
    localparam int CIW = $clog2(COLS);

    for (genvar lr = 0; lr < LR; lr++) begin : g_row
        for (genvar lc = 0; lc < LC; lc++) begin : g_col
            localparam int LN  = lr*LC + lc;
            localparam int CPR = (lr + HALO) / CHUNK_H;
            localparam int CPC = (lc + HALO) / CHUNK_W;

            typedef struct packed {
                logic              pend;
                logic [IDW-1:0]    chunk;
                logic [SLOT_W-1:0] slot;
                logic              rv;
                logic [W-1:0]      data;
            } lane_t;

            lane_t              st_d, st_q;
            logic               want;
            logic [IDW-1:0]     want_chunk;
            logic [SLOT_W-1:0]  want_slot;
            logic [RIW-1:0]     ri;
            logic [CIW-1:0]     ci;

            always_comb begin
                want       = st_q.pend;
                want_chunk = st_q.chunk;
                want_slot  = st_q.slot;
                if (req_valid[LN]) begin
                    want       = 1'b1;
                    want_chunk = req_chunk[LN*IDW +: IDW];
                    want_slot  = req_slot[LN*SLOT_W +: SLOT_W];
                end
                ri = RIW'(CPR*CHUNK_H) + RIW'(want_slot[2]);
                ci = CIW'(CPC*CHUNK_W) + CIW'(want_slot[1:0]);
                st_d.pend  = want;
                st_d.chunk = want_chunk;
                st_d.slot  = want_slot;
                st_d.rv    = 1'b0;
                st_d.data  = st_q.data;
                if (want && (tags[CPR][CPC] == want_chunk)) begin
                    st_d.rv   = 1'b1;
                    st_d.data = cells[ri][ci];
                    st_d.pend = 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end

            assign res_valid[LN]        = st_q.rv;
            assign res_data[LN*W +: W]  = st_q.data;
            assign pend[LN]             = st_q.pend;
        end
    end
endmodule

// File: rtl/gridlk_engine.sv
`timescale 1ns/1ps
module gridlk_engine import gridlk_pkg::*; #(
    parameter int ROWS   = 20,
    parameter int COLS   = 20,
    parameter int W      = 8,
    parameter int HALO   = 2,
    parameter int OBS_CR = 4,
    parameter int OBS_CC = 2,
    localparam int NCR   = ROWS/CHUNK_H,
    localparam int NCC   = COLS/CHUNK_W,
    localparam int NCH   = NCR*NCC,
    localparam int IDW   = $clog2(NCH),
    localparam int LANES = (ROWS-2*HALO)*(COLS-2*HALO)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_valid,
    input  logic [COLS*W-1:0]          load_row,
    input  logic                       shift_valid,
    input  logic [1:0]                 shift_dir,
    input  logic [LANES-1:0]           req_valid,
    input  logic [LANES*IDW-1:0]       req_chunk,
    input  logic [LANES*SLOT_W-1:0]    req_slot,
    output logic [LANES-1:0]           res_valid,
    output logic [LANES*W-1:0]         res_data,
    output logic [NCH-1:0]             seen,
    output logic                       lookup_done
);
    logic [ROWS-1:0][COLS-1:0][W-1:0]  cells_w;
    logic [NCR-1:0][NCC-1:0][IDW-1:0]  tags_w;
    logic                              load_start_w;
    logic                              shift_take_w;
    logic                              loading_w;
    logic [LANES-1:0]                  pend_w;

    gridlk_store #(.ROWS(ROWS), .COLS(COLS), .W(W)) store_i (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_row   (load_row),
        .shift_valid(shift_valid),
        .shift_dir  (shift_dir),
        .cells      (cells_w),
        .load_start (load_start_w),
        .shift_take (shift_take_w),
        .loading    (loading_w)
    );

    gridlk_tags #(.NCR(NCR), .NCC(NCC), .OBS_CR(OBS_CR), .OBS_CC(OBS_CC),
                  .NCH(NCH), .IDW(IDW)) tags_i (
        .clk        (clk),
        .rst        (rst),
        .load_start (load_start_w),
        .shift_take (shift_take_w),
        .shift_dir  (shift_dir),
        .tags       (tags_w),
        .seen       (seen),
        .done       (lookup_done)
    );

    gridlk_lanes #(.ROWS(ROWS), .COLS(COLS), .W(W), .HALO(HALO), .NCR(NCR),
                   .NCC(NCC), .IDW(IDW), .LANES(LANES)) lanes_i (
        .clk       (clk),
        .rst       (rst),
        .cells     (cells_w),
        .tags      (tags_w),
        .req_valid (req_valid),
        .req_chunk (req_chunk),
        .req_slot  (req_slot),
        .res_valid (res_valid),
        .res_data  (res_data),
        .pend      (pend_w)
    );
endmodule

// File: rtl/gridlk_engine_chk.sv
`timescale 1ns/1ps
module gridlk_engine_chk #(
    parameter int LANES = 256,
    parameter int NCH   = 50,
    parameter int TAGW  = 300
) (
    input logic             clk,
    input logic             rst,
    input logic             load_start,
    input logic             loading,
    input logic [TAGW-1:0]  tags,
    input logic [NCH-1:0]   seen,
    input logic             done,
    input logic [LANES-1:0] res_valid,
    input logic [LANES-1:0] req_valid,
    input logic [LANES-1:0] pend
);
    p_seen_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(load_start) |-> ((seen & $past(seen)) == $past(seen)));

    p_seen_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(load_start) |-> ($countones(seen) <= $countones($past(seen)) + 1));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !load_start) |=> done);

    p_tags_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        loading |=> $stable(tags));

    p_result_cause_r4: assert property (@(posedge clk) disable iff (rst)
        (|res_valid) |-> $past(|(req_valid | pend)));
endmodule

bind gridlk_engine gridlk_engine_chk #(.LANES(LANES), .NCH(NCH), .TAGW(NCR*NCC*IDW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .load_start (load_start_w),
    .loading    (loading_w),
    .tags       (tags_w),
    .seen       (seen),
    .done       (lookup_done),
    .res_valid  (res_valid),
    .req_valid  (req_valid),
    .pend       (pend_w)
);

// File: tb/gridlk_engine_tb_top.sv
`timescale 1ns/1ps
module gridlk_engine_tb_top;
    localparam int ROWS = 8, COLS = 8, W = 8, HALO = 2;
    localparam int NLANE = 16, IDW = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               load_valid = 1'b0;
    logic [COLS*W-1:0]  load_row = '0;
    logic               shift_valid = 1'b0;
    logic [1:0]         shift_dir = 2'd0;
    logic [NLANE-1:0]   req_valid = '0;
    logic [NLANE*IDW-1:0] req_chunk = '0;
    logic [NLANE*3-1:0] req_slot = '0;
    logic [NLANE-1:0]   res_valid;
    logic [NLANE*W-1:0] res_data;
    logic [7:0]         seen;
    logic               lookup_done;

    always #5 clk = ~clk;

    gridlk_engine #(.ROWS(ROWS), .COLS(COLS), .W(W), .HALO(HALO),
                    .OBS_CR(1), .OBS_CC(0)) dut_i (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_row(load_row),
        .shift_valid(shift_valid), .shift_dir(shift_dir), .req_valid(req_valid),
        .req_chunk(req_chunk), .req_slot(req_slot), .res_valid(res_valid),
        .res_data(res_data), .seen(seen), .lookup_done(lookup_done)
    );

    int n_chk = 0, n_fail = 0;
    int off_r = 0, off_c = 0, salt = 0;

    // stimulus vectors: [9:7] move code (4 = none), [6:3] lane, [2:0] slot
    localparam logic [9:0] VEC [10] = '{
        {3'd4, 4'd0,  3'd0}, {3'd4, 4'd15, 3'd7}, {3'd4, 4'd5,  3'd3},
        {3'd0, 4'd0,  3'd4}, {3'd0, 4'd10, 3'd6}, {3'd2, 4'd3,  3'd1},
        {3'd1, 4'd12, 3'd2}, {3'd3, 4'd15, 3'd5}, {3'd1, 4'd6,  3'd7},
        {3'd0, 4'd9,  3'd0}
    };

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_tag(int cpr, int cpc);
        return ((cpr + off_r) % 4) * 2 + ((cpc + off_c) % 2);
    endfunction

    function automatic int exp_word(int r, int c);
        return ((r + 2*off_r) % 8) * 16 + ((c + 4*off_c) % 8) + salt;
    endfunction

    function automatic int lane_cpr(int ln); return (ln/4 + HALO) / 2; endfunction
    function automatic int lane_cpc(int ln); return (ln%4 + HALO) / 4; endfunction

    task automatic do_shift(int dir);
        shift_valid = 1'b1;
        shift_dir   = 2'(dir);
        tick();
        shift_valid = 1'b0;
        case (dir)
            0: off_r = (off_r + 1) % 4;
            1: off_r = (off_r + 3) % 4;
            default: off_c = (off_c + 1) % 2;
        endcase
    endtask

    task automatic do_load(int s, bit meddle);
        for (int r = 0; r < ROWS; r++) begin
            load_valid = 1'b1;
            for (int c = 0; c < COLS; c++) load_row[c*W +: W] = 8'(r*16 + c + s);
            shift_valid = meddle && (r == 0);
            shift_dir   = 2'd0;
            tick();
            if (meddle && r == 3) begin
                load_valid  = 1'b0;
                shift_valid = 1'b1;
                shift_dir   = 2'd2;
                tick();
            end
        end
        load_valid  = 1'b0;
        shift_valid = 1'b0;
        off_r = 0; off_c = 0; salt = s;
    endtask

    task automatic lookup(int ln, int slot, string rq);
        int cpr = lane_cpr(ln);
        int cpc = lane_cpc(ln);
        int ex  = exp_word(cpr*2 + slot/4, cpc*4 + slot%4);
        req_valid = '0;
        req_valid[ln] = 1'b1;
        req_chunk[ln*IDW +: IDW] = 3'(exp_tag(cpr, cpc));
        req_slot[ln*3 +: 3] = 3'(slot);
        tick();
        req_valid = '0;
        chk(rq, int'(res_valid[ln]), 1);
        chk(rq, int'(res_data[ln*W +: W]), ex);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        // R1: reset state
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 seen", int'(seen), 0);
        chk("R1 done", int'(lookup_done), 0);
        rst = 1'b0;
        tick();
        // R8: identity tag 2 at observer tile (1,0)
        chk("R8 seen after reset", int'(seen), 4);

        do_load(0, 1'b0);
        chk("R2 seen after load", int'(seen), 4);
        lookup(0, 0, "R8 lane0 tile2");
        lookup(15, 7, "R9 lane15 tile5");

        // R3/R5: table of moves and lookups
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][9:7] != 3'd4) do_shift(int'(VEC[i][9:7]));
            lookup(int'(VEC[i][6:3]), int'(VEC[i][2:0]), "R3/R5 vector");
        end

        // R4: waiting request served once the tile arrives
        req_valid[0] = 1'b1;
        req_chunk[0 +: IDW] = 3'(exp_tag(2, 0));
        req_slot[0 +: 3] = 3'd5;
        tick();
        req_valid = '0;
        chk("R4 not resident", int'(res_valid[0]), 0);
        tick();
        chk("R4 still waiting", int'(res_valid[0]), 0);
        do_shift(0);
        chk("R4 served after move edge", int'(res_valid[0]), 0);
        tick();
        chk("R4 served", int'(res_valid[0]), 1);
        chk("R4 served data", int'(res_data[0 +: W]), exp_word(3, 1));
        tick();
        chk("R4 single pulse", int'(res_valid[0]), 0);

        // R4: replacement of a waiting request
        req_valid[0] = 1'b1;
        req_chunk[0 +: IDW] = 3'(exp_tag(2, 0));
        req_slot[0 +: 3] = 3'd0;
        tick();
        req_chunk[0 +: IDW] = 3'(exp_tag(1, 0));
        req_slot[0 +: 3] = 3'd2;
        tick();
        req_valid = '0;
        chk("R4 replace valid", int'(res_valid[0]), 1);
        chk("R4 replace data", int'(res_data[0 +: W]), exp_word(2, 2));
        do_shift(0);
        tick();
        chk("R4 old request dropped", int'(res_valid[0]), 0);

        // R6: moves during a table write are dropped
        do_load(128, 1'b1);
        chk("R2 seen cleared by load", int'(seen), 4);
        lookup(0, 0, "R6 lane0 after load");
        lookup(15, 7, "R6 lane15 after load");

        // R7: checklist sweep
        for (int i = 0; i < 4; i++) do_shift(0);
        chk("R7 half seen", int'(seen), 8'h55);
        chk("R7 not done", int'(lookup_done), 0);
        do_shift(2);
        for (int i = 0; i < 4; i++) do_shift(0);
        tick();
        chk("R7 all seen", int'(seen), 8'hFF);
        chk("R7 done", int'(lookup_done), 1);
        finish_run();
    end
endmodule